// File: doc/BRIEF.md
# Dock Data Latch Loader

This block owns the word-wide data latch of a single dock together with the one-bit summary flag that mirrors the latch's top bit. Latch bits are numbered 1 through 37, so bit 37 is the most significant bit. The latch is split into two halves. The upper half is bits 37..20 (18 bits). The lower half is bits 19..1 (19 bits).

The block applies four kinds of update, each on a single clock edge:

- A literal load into the upper half only.
- A literal load into the lower half only.
- A combined literal load. The literal fills one half, and the other half is filled with a constant of all zeros or all ones, chosen by a 2-bit select.
- A whole-word capture from the dock's data input.

Predicate evaluation happens upstream. That logic presents one enable that is already qualified, plus a decoded load kind. When the enable is low the latch does nothing.

A capture strobe that arrives in the same cycle as a literal load wins. The summary flag is rewritten every time bit 37 is written, so downstream logic can test the sign of the held word without reading the latch.

Top module: `dock_data_latch`

## Requirements
- R1: With `load_en`=1, `cap_strobe`=0 and `load_kind`=2'b01 (upper load), bits 37..20 take `lit_field[18:1]` on the next edge and bits 19..1 keep their value.
- R2: With `load_en`=1, `cap_strobe`=0 and `load_kind`=2'b10 (lower load), bits 19..1 take `lit_field[19:1]` on the next edge, while bits 37..20 and `sum_flag` keep their value.
- R3: A combined load (`load_kind`=2'b11) with `load_sel`=2'b00 puts `lit_field[18:1]` in bits 37..20 and zeros in bits 19..1.
- R4: A combined load with `load_sel`=2'b01 puts `lit_field[18:1]` in bits 37..20 and ones in bits 19..1.
- R5: A combined load with `load_sel`=2'b10 puts zeros in bits 37..20 and `lit_field[19:1]` in bits 19..1. With `load_sel`=2'b11 it puts ones in bits 37..20 and `lit_field[19:1]` in bits 19..1. Select bit 1 picks the half that receives the literal, and select bit 0 gives the fill value.
- R6: Whenever bit 37 is written, `sum_flag` takes the same value on the same edge. An upper load therefore copies `lit_field[18]` into the flag, and `sum_flag` equals `latch_q[37]` in every cycle.
- R7: With `load_en`=1 and `cap_strobe`=1, the whole latch takes `cap_word` on the next edge whatever `load_kind` holds.
- R8: With `load_en`=0, or with `load_en`=1, `cap_strobe`=0 and `load_kind`=2'b00, the latch and the flag keep their values.
- R9: A synchronous active-low reset clears the latch and the flag to zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Predicate-qualified enable for every update |
| load_kind | input | 2 | 00 none, 01 upper, 10 lower, 11 combined |
| load_sel | input | 2 | Combined-load select: bit 1 = literal half, bit 0 = fill value |
| lit_field | input | 19 | Literal field, bits 19..1 |
| cap_strobe | input | 1 | Whole-word capture request |
| cap_word | input | 37 | Word captured from the data input, bits 37..1 |
| latch_q | output | 37 | Data latch, bits 37..1 |
| sum_flag | output | 1 | Summary flag, mirrors bit 37 |

## Verification
The checker watches several behaviours on every clock:

- the flag equals bit 37;
- a split load leaves the untouched half intact;
- a capture overrides any literal load;
- a disabled cycle changes nothing;
- reset clears the state;
- a zero-fill combined load clears the lower half.

The other fill encodings are shown only through the bench scenarios, which the cycle-accurate model compares against. These are select values 01, 10 and 11, and the exact placement of literal bits in each half. The same applies to long mixed sequences of loads, where a wrong bit would surface only after later loads.

// File: rtl/dl_pkg.sv
// Package: shared types for the dock data latch loader.
// Assumes: load-kind codes are fixed by the upstream decoder.
package dl_pkg;
    typedef enum logic [1:0] {
        LK_NONE  = 2'b00,
        LK_UPPER = 2'b01,
        LK_LOWER = 2'b10,
        LK_FULL  = 2'b11
    } load_kind_e;
endpackage

// File: rtl/dl_next_calc.sv
// Module: dl_next_calc
// Computes per-half write enables and next values for the data latch.
// Assumes: LO_W > HI_W, and the literal is LO_W bits wide, indexed from 1.
module dl_next_calc
    import dl_pkg::*;
#(
    parameter int HI_W = 18,
    parameter int LO_W = 19,
    localparam int WORD_W = HI_W + LO_W
) (
    input  logic              en,
    input  load_kind_e        kind,
    input  logic [1:0]        sel,
    input  logic [LO_W:1]     lit,
    input  logic              cap,
    input  logic [WORD_W:1]   cap_word,
    output logic              hi_we,
    output logic              lo_we,
    output logic [HI_W:1]     hi_nxt,
    output logic [LO_W:1]     lo_nxt
);
    // Select source and write enables: capture first, then literal kinds.
    always_comb begin
        hi_we  = 1'b0;
        lo_we  = 1'b0;
        hi_nxt = lit[HI_W:1];
        lo_nxt = lit;
        if (en) begin
            if (cap) begin
                hi_we  = 1'b1;
                lo_we  = 1'b1;
                hi_nxt = cap_word[WORD_W:LO_W+1];
                lo_nxt = cap_word[LO_W:1];
            end else begin
                case (kind)
                    LK_UPPER: hi_we = 1'b1;
                    LK_LOWER: lo_we = 1'b1;
                    LK_FULL: begin
                        hi_we = 1'b1;
                        lo_we = 1'b1;
                        if (sel[1]) begin
                            hi_nxt = {HI_W{sel[0]}};
                        end else begin
                            lo_nxt = {LO_W{sel[0]}};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dl_half_reg.sv
// Module: dl_half_reg
// One half of the data latch, with its own write enable.
// Assumes: synchronous active-low reset clears to zero.
module dl_half_reg #(
    parameter int W = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [W:1] d,
    output logic [W:1] q
);
    // Hold or load the half each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/dl_summary.sv
// Module: dl_summary
// Summary flag: reloaded with the new top latch bit whenever the upper half is written.
// Assumes: the write strobe is the same one that drives the upper half.
module dl_summary (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic top_bit,
    output logic flag
);
    // Track the top bit on every write of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (we) begin
            flag <= top_bit;
        end
    end
endmodule

// File: rtl/dock_data_latch.sv
// Module: dock_data_latch
// Data latch of one dock plus its summary flag. Applies literal loads
// (upper, lower, combined with fill) and whole-word capture.
// Assumes: load_en is already qualified by the predicate upstream.
module dock_data_latch
    import dl_pkg::*;
#(
    parameter int HI_W = 18,
    parameter int LO_W = 19,
    localparam int WORD_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [1:0]        load_kind,
    input  logic [1:0]        load_sel,
    input  logic [LO_W:1]     lit_field,
    input  logic              cap_strobe,
    input  logic [WORD_W:1]   cap_word,
    output logic [WORD_W:1]   latch_q,
    output logic              sum_flag
);
    load_kind_e       kind_e;
    logic             hi_we;
    logic             lo_we;
    logic [HI_W:1]    hi_nxt;
    logic [LO_W:1]    lo_nxt;
    logic [HI_W:1]    hi_q;
    logic [LO_W:1]    lo_q;

    assign kind_e = load_kind_e'(load_kind);

    dl_next_calc #(.HI_W(HI_W), .LO_W(LO_W)) u_calc (
        .en       (load_en),
        .kind     (kind_e),
        .sel      (load_sel),
        .lit      (lit_field),
        .cap      (cap_strobe),
        .cap_word (cap_word),
        .hi_we    (hi_we),
        .lo_we    (lo_we),
        .hi_nxt   (hi_nxt),
        .lo_nxt   (lo_nxt)
    );

    dl_half_reg #(.W(HI_W)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hi_we),
        .d     (hi_nxt),
        .q     (hi_q)
    );

    dl_half_reg #(.W(LO_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lo_we),
        .d     (lo_nxt),
        .q     (lo_q)
    );

    dl_summary u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (hi_we),
        .top_bit (hi_nxt[HI_W]),
        .flag    (sum_flag)
    );

    assign latch_q = {hi_q, lo_q};
endmodule

// File: rtl/dl_latch_checker.sv
// Module: dl_latch_checker
// Temporal checks on the dock data latch, bound to its ports.
// Assumes: same parameters as the bound top.
module dl_latch_checker #(
    parameter int HI_W = 18,
    parameter int LO_W = 19,
    localparam int WORD_W = HI_W + LO_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [1:0]        load_kind,
    input logic [1:0]        load_sel,
    input logic [LO_W:1]     lit_field,
    input logic              cap_strobe,
    input logic [WORD_W:1]   cap_word,
    input logic [WORD_W:1]   latch_q,
    input logic              sum_flag
);
    logic lit_go;
    assign lit_go = load_en && !cap_strobe;

    AST_UPPER_KEEPS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        lit_go && load_kind == 2'b01 |=> latch_q[LO_W:1] == $past(latch_q[LO_W:1])
            && latch_q[WORD_W:LO_W+1] == $past(lit_field[HI_W:1])); // R1
    AST_LOWER_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        lit_go && load_kind == 2'b10 |=> latch_q[WORD_W:LO_W+1] == $past(latch_q[WORD_W:LO_W+1])
            && $stable(sum_flag)); // R2
    AST_ZERO_FILL_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        lit_go && load_kind == 2'b11 && load_sel == 2'b00 |=> latch_q[LO_W:1] == '0); // R3
    AST_FLAG_MIRRORS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        sum_flag == latch_q[WORD_W]); // R6
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && cap_strobe |=> latch_q == $past(cap_word)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(latch_q) && $stable(sum_flag)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> latch_q == '0 && !sum_flag); // R9
endmodule

bind dock_data_latch dl_latch_checker #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_kind  (load_kind),
    .load_sel   (load_sel),
    .lit_field  (lit_field),
    .cap_strobe (cap_strobe),
    .cap_word   (cap_word),
    .latch_q    (latch_q),
    .sum_flag   (sum_flag)
);

// File: tb/test_dock_data_latch.sv
`timescale 1ns/1ps
module test_dock_data_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [1:0]  load_kind = 2'b00;
    logic [1:0]  load_sel = 2'b00;
    logic [19:1] lit_field = '0;
    logic        cap_strobe = 1'b0;
    logic [37:1] cap_word = '0;
    logic [37:1] latch_q;
    logic        sum_flag;

    logic [37:1] ref_d = '0;
    logic        ref_s = 1'b0;
    int          vectors = 0;
    int          miscompares = 0;

    always #4 clk = ~clk;

    dock_data_latch i_dock_data_latch (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_kind(load_kind),
        .load_sel(load_sel), .lit_field(lit_field), .cap_strobe(cap_strobe),
        .cap_word(cap_word), .latch_q(latch_q), .sum_flag(sum_flag)
    );

    // Behavioural model of one edge, written from the requirements.
    task automatic model_edge();
        if (!rst_n) begin
            ref_d = '0;
            ref_s = 1'b0;
        end else if (load_en) begin
            if (cap_strobe) begin
                ref_d = cap_word;
                ref_s = cap_word[37];
            end else if (load_kind == 2'b01) begin
                ref_d[37:20] = lit_field[18:1];
                ref_s = lit_field[18];
            end else if (load_kind == 2'b10) begin
                ref_d[19:1] = lit_field;
            end else if (load_kind == 2'b11) begin
                case (load_sel)
                    2'b00: ref_d = {lit_field[18:1], 19'h00000};
                    2'b01: ref_d = {lit_field[18:1], 19'h7FFFF};
                    2'b10: ref_d = {18'h00000, lit_field};
                    default: ref_d = {18'h3FFFF, lit_field};
                endcase
                ref_s = ref_d[37];
            end
        end
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (latch_q !== ref_d || sum_flag !== ref_s) begin
            miscompares++;
            $display("FAIL %s: latch=%h flag=%b expected latch=%h flag=%b",
                     tag, latch_q, sum_flag, ref_d, ref_s);
        end
    endtask

    task automatic step(input logic rn, input logic en, input logic [1:0] kind,
                        input logic [1:0] sel, input logic [19:1] lit,
                        input logic cap, input logic [37:1] cw, input string tag);
        rst_n = rn; load_en = en; load_kind = kind; load_sel = sel;
        lit_field = lit; cap_strobe = cap; cap_word = cw;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(0, 0, 2'b00, 2'b00, '0, 0, '0, "R9 reset");
        step(0, 1, 2'b11, 2'b11, 19'h7FFFF, 0, '0, "R9 reset ignores load");
        // R1 upper load, top literal bit set so flag rises (R6)
        step(1, 1, 2'b01, 2'b00, 19'h2ABCD, 0, '0, "R1 upper load");
        step(1, 1, 2'b10, 2'b00, 19'h5A5A5, 0, '0, "R2 lower load");
        step(1, 1, 2'b01, 2'b00, 19'h4C3B2, 0, '0, "R6 upper load copies lit18");
        step(1, 1, 2'b10, 2'b00, 19'h00001, 0, '0, "R2 lower keeps upper and flag");
        step(1, 1, 2'b11, 2'b00, 19'h7F0F3, 0, '0, "R3 full sel00");
        step(1, 1, 2'b11, 2'b01, 19'h1F0F3, 0, '0, "R4 full sel01");
        step(1, 1, 2'b11, 2'b10, 19'h6DEAD, 0, '0, "R5 full sel10");
        step(1, 1, 2'b11, 2'b11, 19'h0BEEF, 0, '0, "R5 full sel11");
        step(1, 1, 2'b11, 2'b00, 19'h20000, 0, '0, "R6 full load flag");
        step(1, 1, 2'b11, 2'b01, 19'h12345, 1, 37'h0_1234_5678, "R7 capture beats literal");
        step(1, 1, 2'b00, 2'b00, '0, 1, 37'h1F_FFFF_0001, "R7 capture alone");
        step(1, 0, 2'b11, 2'b10, 19'h00000, 1, '0, "R8 disabled capture and load");
        step(1, 0, 2'b01, 2'b00, 19'h00000, 0, '0, "R8 disabled upper load");
        step(1, 1, 2'b00, 2'b11, 19'h7FFFF, 0, '0, "R8 kind none");
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  k = 2'($urandom);
            logic        c = ($urandom % 5) == 0;
            logic        e = ($urandom % 6) != 0;
            string       t;
            if (!e)          t = "R8 random idle";
            else if (c)      t = "R7 random capture";
            else if (k == 2'b01) t = "R1 random upper";
            else if (k == 2'b10) t = "R2 random lower";
            else if (k == 2'b11) t = "R5 random full";
            else             t = "R8 random none";
            step(1, e, k, 2'($urandom), 19'($urandom), c, 37'({$urandom, $urandom}), t);
        end
        step(1, 1, 2'b11, 2'b11, 19'h7FFFF, 0, '0, "R6 all ones");
        step(0, 1, 2'b01, 2'b00, 19'h7FFFF, 0, '0, "R9 mid-run reset");
        step(1, 0, 2'b00, 2'b00, '0, 0, '0, "R9 after reset");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule